// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the basic control register (register 0) of a 10/100 Ethernet PHY. A serial management frame decoder, which is not part of this block, delivers writes as a one-cycle strobe with 16 bits of data. The block returns the current register value for reads. Four bits are implemented:

| Bit | Function |
|-----|----------|
| 12 | Auto-negotiation enable |
| 11 | Low-power request |
| 10 | MAC-side isolation |
| 9 | Auto-negotiation restart |

The other bits read as zero.

The register state drives the pad controls for the MAC-side data pins and the transmit-pair tri-state. It also raises a one-cycle pulse that clears the latching status bits held elsewhere in the management register set. Two rules set the reset state and the restart behaviour:

- The reset value of the isolation bit depends on the strapped PHY address.
- A restart request is accepted only while auto-negotiation is enabled. It clears itself once the auto-negotiation engine reports that it has started.

Top module: `phy_basic_ctl`

## Requirements
- R1: Reset loads the enable bit (bit 12) with 1 and the low-power (bit 11) and restart (bit 9) bits with 0. It loads the isolation bit (bit 10) with 1 when the strapped address is 5'b00000, and with 0 for any other address. A read right after reset returns 16'h1400 for address zero and 16'h1000 otherwise.
- R2: A write takes effect on the clock edge where its strobe is high, and the new value is visible on `rd_data` in the following cycle. Bits 15:13 and 8:0 always read as 0, whatever was written to them.
- R3: A write sets bit 9 only when that same write also carries bit 12 as 1. A write of bit 9 as 1 together with bit 12 as 0 leaves bit 9 at 0.
- R4: Bit 9 returns to 0 on the first edge where `an_started` is high and no write occurs. A write carrying bit 12 as 0 also clears bit 9. A write that sets bit 9 takes priority over `an_started` on the same edge.
- R5: While bit 11 is 1, the MAC-side outputs are driven (`mac_out_oe` = 1) and forced low (`mac_out_force_low` = 1), the MAC-side inputs are gated off (`mac_in_gate` = 1), and the transmit pair is tri-stated (`tp_tx_tristate` = 1). This holds whatever the value of bit 10.
- R6: While bit 10 is 1 and bit 11 is 0, the MAC-side outputs are high-impedance (`mac_out_oe` = 0, `mac_out_force_low` = 0) and the inputs are gated off (`mac_in_gate` = 1). The transmit pair is not tri-stated.
- R7: While bits 10 and 11 are both 0, `mac_out_oe` = 1, `mac_out_force_low` = 0, `mac_in_gate` = 0 and `tp_tx_tristate` = 0.
- R8: `latch_clr` is high for exactly one cycle, the cycle after the edge on which bit 11 goes from 0 to 1. It stays low when bit 11 stays 1 or falls to 0.
- R9: Low power and isolation do not stop the management path. Writes made while either mode is active are applied, and reads return them. Entering low power leaves every other bit of this register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Management-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped PHY address, sampled during reset |
| wr_en | input | 1 | One-cycle write strobe for register 0 |
| wr_data | input | 16 | Data to be written |
| an_started | input | 1 | Auto-negotiation engine reports that a restart has begun |
| rd_data | output | 16 | Current register value |
| mac_out_oe | output | 1 | Output enable for the MAC-side output pads |
| mac_out_force_low | output | 1 | Forces the MAC-side output pads to 0 |
| mac_in_gate | output | 1 | Gates off the MAC-side inputs |
| tp_tx_tristate | output | 1 | Tri-states the twisted-pair transmit outputs |
| latch_clr | output | 1 | One-cycle re-initialisation pulse for the latching status bits |

## Verification
Every output is a function of the register state alone, so a wrong stored bit shows on `rd_data` and on the pad controls in the cycle right after the edge that caused it. A lost or stuck restart shows on the cycle after the `an_started` edge or after the ignored write. A wrong low-power edge history shows only through `latch_clr`: it appears as a missing pulse, a pulse that lasts two cycles, or a pulse on a rewrite. The bench therefore compares a behavioural model with every port on every cycle, including stretches of random writes.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 5;
  localparam int BIT_AN  = 12;
  localparam int BIT_LP  = 11;
  localparam int BIT_ISO = 10;
  localparam int BIT_RS  = 9;

  typedef struct packed {
    logic an_en;
    logic lp;
    logic iso;
    logic rs;
  } ctl_bits_t;

  typedef struct packed {
    logic oe;
    logic force_low;
    logic in_gate;
    logic tp_tri;
  } pad_ctl_t;

  // Pad policy: low power dominates isolation.
  function automatic pad_ctl_t pad_policy(input logic lp, input logic iso);
    pad_ctl_t p;
    p.tp_tri    = lp;
    p.force_low = lp;
    p.oe        = lp | ~iso;
    p.in_gate   = lp | iso;
    return p;
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(input ctl_bits_t b);
    logic [REG_W-1:0] v;
    v          = '0;
    v[BIT_AN]  = b.an_en;
    v[BIT_LP]  = b.lp;
    v[BIT_ISO] = b.iso;
    v[BIT_RS]  = b.rs;
    return v;
  endfunction

  function automatic logic iso_reset_value(input logic [ADDR_W-1:0] addr);
    return (addr == '0);
  endfunction
endpackage

// File: rtl/phyctl_reg_core.sv
module phyctl_reg_core
  import phy_ctl_pkg::*;
#(
  parameter int  DW       = REG_W,
  parameter int  AW       = ADDR_W,
  parameter bit  AN_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          an_started,
  output ctl_bits_t     bits
);
  ctl_bits_t cur;
  logic      rs_set, rs_kill, rs_done;

  // Named events for assertions
  assign rs_set  = wr_en & wr_data[BIT_AN] & wr_data[BIT_RS];
  assign rs_kill = wr_en & ~wr_data[BIT_AN];
  assign rs_done = ~wr_en & an_started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur.an_en <= AN_RESET;
      cur.lp    <= 1'b0;
      cur.iso   <= iso_reset_value(phy_addr);
      cur.rs    <= 1'b0;
    end else begin
      if (wr_en) begin
        cur.an_en <= wr_data[BIT_AN];
        cur.lp    <= wr_data[BIT_LP];
        cur.iso   <= wr_data[BIT_ISO];
      end
      if (rs_set)
        cur.rs <= 1'b1;
      else if (rs_kill || rs_done)
        cur.rs <= 1'b0;
    end
  end

  assign bits = cur;

  AST_RS_NEEDS_AN: assert property (@(posedge clk) disable iff (!rst_n)
    cur.rs |-> cur.an_en); // R3
  AST_RS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    rs_kill |=> !cur.rs); // R3
  AST_RS_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rs_done |=> !cur.rs); // R4
  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cur.lp == $past(wr_data[BIT_LP])) && (cur.iso == $past(wr_data[BIT_ISO]))); // R9
endmodule

// File: rtl/phyctl_pad_ctrl.sv
module phyctl_pad_ctrl
  import phy_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lp,
  input  logic     iso,
  output pad_ctl_t pads
);
  assign pads = pad_policy(lp, iso);

  AST_LP_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    lp |-> pads.oe && pads.force_low && pads.in_gate && pads.tp_tri); // R5
  AST_ISO_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (iso && !lp) |-> !pads.oe && pads.in_gate && !pads.tp_tri); // R6
  AST_NORMAL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!iso && !lp) |-> pads.oe && !pads.force_low && !pads.in_gate); // R7
endmodule

// File: rtl/phyctl_lp_edge.sv
module phyctl_lp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lp,
  output logic pulse
);
  logic lp_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_prev <= 1'b0;
    else        lp_prev <= lp;
  end

  assign pulse = lp & ~lp_prev;

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R8
endmodule

// File: rtl/phy_basic_ctl.sv
module phy_basic_ctl
  import phy_ctl_pkg::*;
#(
  parameter int DW       = REG_W,
  parameter int AW       = ADDR_W,
  parameter bit AN_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          an_started,
  output logic [DW-1:0] rd_data,
  output logic          mac_out_oe,
  output logic          mac_out_force_low,
  output logic          mac_in_gate,
  output logic          tp_tx_tristate,
  output logic          latch_clr
);
  ctl_bits_t bits;
  pad_ctl_t  pads;
  logic      lp_rise;

  phyctl_reg_core #(.DW(DW), .AW(AW), .AN_RESET(AN_RESET)) u_core (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .wr_en(wr_en),
    .wr_data(wr_data), .an_started(an_started), .bits(bits)
  );

  phyctl_pad_ctrl u_pads (
    .clk(clk), .rst_n(rst_n), .lp(bits.lp), .iso(bits.iso), .pads(pads)
  );

  phyctl_lp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lp(bits.lp), .pulse(lp_rise)
  );

  assign rd_data           = DW'(pack_reg(bits));
  assign mac_out_oe        = pads.oe;
  assign mac_out_force_low = pads.force_low;
  assign mac_in_gate       = pads.in_gate;
  assign tp_tx_tristate    = pads.tp_tri;
  assign latch_clr         = lp_rise;

  AST_CLR_ON_LP: assert property (@(posedge clk) disable iff (!rst_n)
    latch_clr |-> tp_tx_tristate && rd_data[BIT_LP]); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~((DW'(1) << BIT_AN) | (DW'(1) << BIT_LP) | (DW'(1) << BIT_ISO) | (DW'(1) << BIT_RS))) == '0); // R2
endmodule

// File: tb/phy_basic_ctl_test.sv
module phy_basic_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  phy_addr = 5'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0;
  logic        an_started = 1'b0;
  logic [15:0] rd_data;
  logic        mac_out_oe, mac_out_force_low, mac_in_gate, tp_tx_tristate, latch_clr;

  int tests = 0;
  int fails = 0;

  // Behavioural reference state
  bit m_an, m_lp, m_iso, m_rs, m_lp_old;

  always #10 clk = ~clk;

  phy_basic_ctl uut (
    .clk(clk), .rst_n(rst_n), .phy_addr(phy_addr), .wr_en(wr_en),
    .wr_data(wr_data), .an_started(an_started), .rd_data(rd_data),
    .mac_out_oe(mac_out_oe), .mac_out_force_low(mac_out_force_low),
    .mac_in_gate(mac_in_gate), .tp_tx_tristate(tp_tx_tristate),
    .latch_clr(latch_clr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_an = 1; m_lp = 0; m_rs = 0; m_lp_old = 0;
      m_iso = (phy_addr == 5'd0);
    end else begin
      m_lp_old = m_lp;
      if (wr_en) begin
        if (wr_data[12] && wr_data[9]) m_rs = 1;
        else if (!wr_data[12])         m_rs = 0;
        m_an  = wr_data[12];
        m_lp  = wr_data[11];
        m_iso = wr_data[10];
      end else if (an_started) begin
        m_rs = 0;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    return (int'(m_an) << 12) | (int'(m_lp) << 11) | (int'(m_iso) << 10) | (int'(m_rs) << 9);
  endfunction

  // Every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 rd_data", rd_data, exp_rd());
      if (m_lp) begin
        check("R5 pads", {mac_out_oe, mac_out_force_low, mac_in_gate, tp_tx_tristate}, 4'b1111);
      end else if (m_iso) begin
        check("R6 pads", {mac_out_oe, mac_out_force_low, mac_in_gate, tp_tx_tristate}, 4'b0010);
      end else begin
        check("R7 pads", {mac_out_oe, mac_out_force_low, mac_in_gate, tp_tx_tristate}, 4'b1000);
      end
      check("R8 latch_clr", latch_clr, int'(m_lp && !m_lp_old));
    end
  end

  task automatic do_write(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic [4:0] a);
    @(negedge clk);
    rst_n = 1'b0; phy_addr = a;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: address zero
    do_reset(5'd0);
    #1 check("R1 reset addr0", rd_data, 16'h1400);
    check("R6 reset isolate pads", {mac_out_oe, mac_in_gate}, 2'b01);
    // R1: nonzero address
    do_reset(5'd5);
    #1 check("R1 reset addr5", rd_data, 16'h1000);
    check("R1 latch_clr low", latch_clr, 0);
    // R3: restart ignored without enable
    do_write(16'h0200);
    #1 check("R3 ignored restart", rd_data, 16'h0000);
    // R3/R4: accepted, then self-cleared
    do_write(16'h1200);
    #1 check("R3 accepted restart", rd_data, 16'h1200);
    @(negedge clk); an_started = 1'b1;
    @(negedge clk); an_started = 1'b0;
    #1 check("R4 self clear", rd_data, 16'h1000);
    // R4: cleared by disabling
    do_write(16'h1200);
    do_write(16'h0000);
    #1 check("R4 clear on disable", rd_data, 16'h0000);
    // R4: write wins over an_started
    @(negedge clk); wr_en = 1; wr_data = 16'h1200; an_started = 1;
    @(negedge clk); wr_en = 0; an_started = 0;
    #1 check("R4 write priority", rd_data, 16'h1200);
    // R8/R9: enter low power, restart kept
    do_write(16'h1A00);
    #1 check("R8 pulse", latch_clr, 1);
    check("R9 bits kept", rd_data, 16'h1A00);
    @(negedge clk); #1 check("R8 pulse ends", latch_clr, 0);
    do_write(16'h1A00);
    #1 check("R8 no pulse on rewrite", latch_clr, 0);
    // R5: both modes
    do_write(16'h1C00);
    #1 check("R5 priority", {mac_out_oe, mac_out_force_low, mac_in_gate, tp_tx_tristate}, 4'b1111);
    // R6/R8: leave low power into isolate
    do_write(16'h1400);
    #1 check("R6 isolate", {mac_out_oe, mac_out_force_low, mac_in_gate, tp_tx_tristate}, 4'b0010);
    check("R8 no pulse on fall", latch_clr, 0);
    // R2/R9: write in isolate, unused bits dropped
    do_write(16'hFFFF);
    #1 check("R2 unused bits", rd_data, 16'h1E00);
    do_write(16'h1000);
    #1 check("R7 normal", {mac_out_oe, mac_out_force_low, mac_in_gate, tp_tx_tristate}, 4'b1000);
    // Random phase; compared by the model every cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_data = 16'($urandom);
      an_started = ($urandom_range(0, 3) == 0);
    end
    @(negedge clk); wr_en = 0; an_started = 0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule